// File: doc/BRIEF.md
# I2C Master Register Front End

This block sits between a host register bus and a byte-level I2C bus engine. It holds five 8-bit registers: own address, clock divider, control, status and data. Register accesses are turned into byte commands for the engine: start with an address byte, send a byte, receive a byte, or stop. The acknowledge result the engine returns is folded back into the status register. A single level interrupt line follows the interrupt flag.

The host presents an access on `host_req` and holds it until `host_ack` pulses for one cycle. An access that needs the bus stalls until the engine has answered. The first data write after a start is taken as the address byte: bits 7:1 are the target and bit 0 is the direction. Status flags clear only when 0 is written to them. The clock divider is kept and exported unchanged to the engine.

Register offsets are: 0 own address, 1 clock divider, 2 control, 3 status, 4 data. The other offsets are unmapped. Control bits are 7 enable, 6 interrupt enable, 5 master, 4 transmit mode and 2 repeated start. Status bits are 5 bus busy, 4 arbitration lost, 1 interrupt flag and 0 received NACK. Engine opcodes on `cmd_op` are 0 start, 1 send, 2 receive and 3 stop.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is low, `clk_div` is 0 and no command is issued.
- R2: Only bits 7:0 of a write are used. The own address keeps bits 7:1 (mask 0xFE), the divider keeps bits 5:0 (mask 0x3F) and control keeps mask 0xFC. `clk_div` always shows the divider register.
- R3: A control write that does not soft-reset copies master (bit 5) into bus busy (status bit 5). Clearing master while a transfer is active issues one stop (opcode 3) and ends the transfer.
- R4: A control write with bit 7 = 0 while the block is enabled is a soft reset. Divider, control, status and data-read registers return to 0 and the transfer ends, with a stop if one was active. The own address is kept.
- R5: A control write with repeated start (bit 2) and master set during an active transfer issues a stop, ends the transfer and reads back with bit 2 cleared. With no active transfer, bit 2 stays as written.
- R6: An interrupt sets status bit 1 only when control bits 7 and 6 are both 1. `irq` equals status bit 1.
- R7: Writing 0 to status bit 1 clears it and drops `irq`. Writing 0 to bit 4 clears it. Writing 1 to either bit, and writing any other status bit, changes nothing.
- R8: A data write while disabled (control bit 7 = 0) issues no command and changes no register.
- R9: With enable and master set and no active transfer, a data write issues a start (opcode 0) carrying the byte. If the engine NACKs, status bit 0 is set and no transfer starts. If it ACKs, bit 0 clears, the transfer becomes active and an interrupt is raised.
- R10: A data write during an active transfer issues a send (opcode 1). On NACK, status bit 0 is set, a stop follows and the transfer ends. On ACK, bit 0 clears and an interrupt is raised.
- R11: A data read with master set returns 0xFF and issues no command when no transfer is active or transmit mode (bit 4) is set. Otherwise it issues a receive (opcode 2), returns the engine byte and raises an interrupt.
- R12: Unmapped offsets read 0 and ignore writes. A data read with master clear returns the last data-read value and issues no command.
- R13: Accesses with no bus command are acknowledged in the cycle after the request. Accesses with a command are acknowledged only after the engine response. `cmd_valid` holds with stable op and byte until `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | AW | Register offset |
| host_wdata | input | WD_W | Write data, low byte used |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 8 | Read data, valid with `host_ack` |
| irq | output | 1 | Level interrupt |
| clk_div | output | 8 | Divider value for the bus engine |
| cmd_valid | output | 1 | Command request to engine |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 2 | Command opcode |
| cmd_byte | output | 8 | Address or data byte for the command |
| rsp_valid | input | 1 | One-cycle engine response |
| rsp_nack | input | 1 | Response was NACK |
| rsp_byte | input | 8 | Received byte for a receive command |

## Verification
The assertions assume a host that holds `host_req` and its fields until `host_ack` and drops them in the following cycle. They also assume an engine that raises `rsp_valid` once per accepted command and never when no command is outstanding. The bench host task releases the request at the first cycle where it sees the acknowledge. The bench engine answers exactly once per handshake, with a latency that rotates from zero to three cycles, so stalls of varied length are covered without breaking either assumption.

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl #(
  parameter int          AW       = 3,
  parameter int          WD_W     = 16,
  parameter logic [7:0]  OWN_MASK = 8'hFE,
  parameter logic [7:0]  DIV_MASK = 8'h3F,
  parameter logic [7:0]  CTL_MASK = 8'hFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [WD_W-1:0] host_wdata,
  output logic          host_ack,
  output logic [7:0]    host_rdata,
  output logic          irq,
  output logic [7:0]    clk_div,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_byte,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  input  logic [7:0]    rsp_byte
);
  localparam logic [AW-1:0] A_OWN = AW'(0), A_DIV = AW'(1), A_CTL = AW'(2),
                            A_STS = AW'(3), A_DAT = AW'(4);
  localparam int C_EN = 7, C_IE = 6, C_MST = 5, C_TX = 4, C_RS = 2;
  localparam int S_BUSY = 5, S_ARB = 4, S_IF = 1, S_NAK = 0;
  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WAIT, ST_DONE} st_t;
  typedef enum logic [1:0] {PA_NONE, PA_ADDR, PA_SEND, PA_RECV} pa_t;

  st_t        st;
  pa_t        pa;
  logic [7:0] r_own, r_div, r_ctl, r_sts, r_drd;
  logic       active;

  logic [7:0] w8, nctl;
  logic       raise_ok, unused_hi;
  assign w8        = host_wdata[7:0];
  assign nctl      = w8 & CTL_MASK;
  assign raise_ok  = r_ctl[C_EN] & r_ctl[C_IE];
  assign unused_hi = ^host_wdata[WD_W-1:8];

  assign host_ack  = (st == ST_DONE);
  assign cmd_valid = (st == ST_CMD);
  assign irq       = r_sts[S_IF];
  assign clk_div   = r_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  pa <= PA_NONE;
      r_own <= '0; r_div <= '0; r_ctl <= '0; r_sts <= '0; r_drd <= '0;
      active <= 1'b0; host_rdata <= '0; cmd_op <= OP_START; cmd_byte <= '0;
    end else begin
      case (st)
        ST_IDLE: if (host_req) begin
          st <= ST_DONE;
          host_rdata <= '0;
          if (!host_we) begin
            case (host_addr)
              A_OWN: host_rdata <= r_own;
              A_DIV: host_rdata <= r_div;
              A_CTL: host_rdata <= r_ctl;
              A_STS: host_rdata <= r_sts;
              A_DAT: begin
                host_rdata <= r_drd;
                if (r_ctl[C_MST]) begin
                  if (!active || r_ctl[C_TX]) begin
                    host_rdata <= 8'hFF;
                    r_drd      <= 8'hFF;
                  end else begin
                    st <= ST_CMD; cmd_op <= OP_RECV; cmd_byte <= '0; pa <= PA_RECV;
                  end
                end
              end
              default: ;
            endcase
          end else begin
            case (host_addr)
              A_OWN: r_own <= w8 & OWN_MASK;
              A_DIV: r_div <= w8 & DIV_MASK;
              A_CTL: begin
                if (r_ctl[C_EN] && !w8[C_EN]) begin
                  r_div <= '0; r_ctl <= '0; r_sts <= '0; r_drd <= '0;
                  active <= 1'b0;
                  if (active) begin
                    st <= ST_CMD; cmd_op <= OP_STOP; cmd_byte <= '0; pa <= PA_NONE;
                  end
                end else begin
                  r_ctl         <= nctl;
                  r_sts[S_BUSY] <= nctl[C_MST];
                  if (active && (!nctl[C_MST] || nctl[C_RS])) begin
                    active <= 1'b0;
                    st <= ST_CMD; cmd_op <= OP_STOP; cmd_byte <= '0; pa <= PA_NONE;
                    if (nctl[C_MST]) r_ctl <= nctl & ~(8'd1 << C_RS);
                  end
                end
              end
              A_STS: begin
                if (!w8[S_IF])  r_sts[S_IF]  <= 1'b0;
                if (!w8[S_ARB]) r_sts[S_ARB] <= 1'b0;
              end
              A_DAT: if (r_ctl[C_EN] && r_ctl[C_MST]) begin
                st       <= ST_CMD;
                cmd_byte <= w8;
                cmd_op   <= active ? OP_SEND : OP_START;
                pa       <= active ? PA_SEND : PA_ADDR;
              end
              default: ;
            endcase
          end
        end
        ST_CMD: if (cmd_ready) st <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          st <= ST_DONE;
          case (pa)
            PA_ADDR: begin
              r_sts[S_NAK] <= rsp_nack;
              if (!rsp_nack) begin
                active <= 1'b1;
                if (raise_ok) r_sts[S_IF] <= 1'b1;
              end
            end
            PA_SEND: begin
              r_sts[S_NAK] <= rsp_nack;
              if (rsp_nack) begin
                active <= 1'b0;
                st <= ST_CMD; cmd_op <= OP_STOP; cmd_byte <= '0; pa <= PA_NONE;
              end else if (raise_ok) r_sts[S_IF] <= 1'b1;
            end
            PA_RECV: begin
              r_drd      <= rsp_byte;
              host_rdata <= rsp_byte;
              if (raise_ok) r_sts[S_IF] <= 1'b1;
            end
            default: ;
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_host_ctrl_chk.sv
module i2c_host_ctrl_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic          host_ack,
  input logic          irq,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_byte,
  input logic [7:0]    ctl
);
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte)); // R13
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack); // R13
  AST_NO_ACK_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !host_ack); // R13
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctl[7] && ctl[6])); // R6
  AST_IRQ_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(host_req && host_we && (host_addr == AW'(2) || host_addr == AW'(3)))); // R7
endmodule

bind i2c_host_ctrl i2c_host_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_ack(host_ack), .irq(irq),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_byte(cmd_byte), .ctl(r_ctl)
);

// File: tb/i2c_host_ctrl_bench.sv
module i2c_host_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [2:0] host_addr = 0;
  logic [15:0] host_wdata = 0;
  logic host_ack, irq, cmd_valid;
  logic [7:0] host_rdata, clk_div, cmd_byte;
  logic [1:0] cmd_op;
  logic cmd_ready = 0, rsp_valid = 0, rsp_nack = 0;
  logic [7:0] rsp_byte = 0;

  int checks = 0, errors = 0;
  int got_q[$], exp_q[$];
  int lat = 0;
  bit in_acc = 1;
  logic [7:0] m_own = 0, m_div = 0, m_ctl = 0, m_sts = 0, m_drd = 0, m_rx = 8'hA0;
  bit m_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_host_ctrl u_i2c_host_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .irq(irq), .clk_div(clk_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .rsp_byte(rsp_byte));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bus engine: target 0x50 answers, byte 0xEE is refused, reads count up from 0xA0
  initial begin : engine
    logic [7:0] rx;
    rx = 8'hA0;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        got_q.push_back(int'(cmd_op) * 256 + int'(cmd_byte));
        cmd_ready = 1;
        rsp_nack  = (cmd_op == 2'd0) ? (cmd_byte[7:1] != 7'h50)
                  : (cmd_op == 2'd1) ? (cmd_byte == 8'hEE) : 1'b0;
        rsp_byte  = (cmd_op == 2'd2) ? rx : 8'h00;
        if (cmd_op == 2'd2) rx++;
        @(negedge clk);
        cmd_ready = 0;
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 4;
        rsp_valid = 1;
        @(negedge clk);
        rsp_valid = 0;
      end
    end
  end

  // idle-time comparison against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !in_acc) begin
      chk("R6 irq", irq, m_sts[1]);
      chk("R2 clk_div", clk_div, m_div);
      chk("R13 idle cmd", cmd_valid, 0);
    end
  end

  task automatic m_raise();
    if (m_ctl[7] && m_ctl[6]) m_sts[1] = 1;
  endtask

  task automatic m_stop();
    exp_q.push_back(3 * 256);
  endtask

  task automatic model(bit we, int a, logic [15:0] w, output logic [7:0] r);
    logic [7:0] b;
    b = w[7:0];
    r = 0;
    if (!we) begin
      case (a)
        0: r = m_own; 1: r = m_div; 2: r = m_ctl; 3: r = m_sts;
        4: begin
          r = m_drd;
          if (m_ctl[5]) begin
            if (!m_act || m_ctl[4]) begin r = 8'hFF; m_drd = 8'hFF; end
            else begin
              exp_q.push_back(2 * 256);
              r = m_rx; m_rx++; m_drd = r; m_raise();
            end
          end
        end
        default: r = 0;
      endcase
    end else begin
      case (a)
        0: m_own = b & 8'hFE;
        1: m_div = b & 8'h3F;
        2: if (m_ctl[7] && !b[7]) begin
             if (m_act) m_stop();
             m_div = 0; m_ctl = 0; m_sts = 0; m_drd = 0; m_act = 0;
           end else begin
             m_ctl = b & 8'hFC;
             m_sts[5] = m_ctl[5];
             if (!m_ctl[5]) begin
               if (m_act) m_stop();
               m_act = 0;
             end else if (m_ctl[2] && m_act) begin
               m_stop(); m_act = 0; m_ctl[2] = 0;
             end
           end
        3: begin
             if (!b[1]) m_sts[1] = 0;
             if (!b[4]) m_sts[4] = 0;
           end
        4: if (m_ctl[7] && m_ctl[5]) begin
             if (!m_act) begin
               exp_q.push_back(b);
               if (b[7:1] == 7'h50) begin m_sts[0] = 0; m_act = 1; m_raise(); end
               else m_sts[0] = 1;
             end else begin
               exp_q.push_back(256 + b);
               if (b == 8'hEE) begin m_sts[0] = 1; m_act = 0; m_stop(); end
               else begin m_sts[0] = 0; m_raise(); end
             end
           end
        default: ;
      endcase
    end
  endtask

  task automatic acc(string tag, bit we, int a, logic [15:0] w);
    logic [7:0] er;
    int n;
    in_acc = 1;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a[2:0]; host_wdata = w;
    n = 0;
    do begin @(negedge clk); n++; end while (!host_ack && n < 100);
    host_req = 0;
    model(we, a, w, er);
    if (!we) chk({tag, " rdata"}, host_rdata, er);
    chk({tag, " cmd count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk({tag, " cmd"}, got_q[i], exp_q[i]);
    if (exp_q.size() == 0) chk({tag, " R13 ack latency"}, n, 1);
    else chk({tag, " R13 stalled"}, int'(n > 2), 1);
    got_q.delete(); exp_q.delete();
    in_acc = 0;
  endtask

  task automatic rd(string tag, int a); acc(tag, 0, a, 0); endtask
  task automatic wr(string tag, int a, logic [15:0] w); acc(tag, 1, a, w); endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    in_acc = 0;
    chk("R1 irq", irq, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    for (int a = 0; a < 5; a++) rd("R1 reset reg", a);
    wr("R2 own", 0, 16'h12FF);  rd("R2 own", 0);
    wr("R2 div", 1, 16'hFFFF);  rd("R2 div", 1);
    wr("R12 unmapped", 5, 16'h00AA); rd("R12 unmapped", 5); rd("R12 unmapped", 7);
    wr("R8 disabled", 4, 16'h00A0); rd("R8 sts", 3); rd("R8 ctl", 2);
    wr("R2 ctl", 2, 16'hFFC0);  rd("R2 ctl", 2);
    rd("R12 slave read", 4);
    wr("R3 master", 2, 16'h00F0); rd("R3 busy", 3);
    rd("R11 no transfer", 4);
    wr("R9 nack", 4, 16'h0042); rd("R9 sts", 3);
    wr("R9 ack", 4, 16'h00A0);  rd("R9 sts", 3);
    wr("R7 write ones", 3, 16'h00FF); rd("R7 sts", 3);
    wr("R7 clear", 3, 16'h00FD); rd("R7 sts", 3);
    wr("R10 send", 4, 16'h0011); rd("R10 sts", 3);
    wr("R7 clear", 3, 16'h0000);
    wr("R10 nack", 4, 16'h00EE); rd("R10 sts", 3);
    wr("R9 restart read", 4, 16'h00A1);
    rd("R11 tx set", 4);
    wr("R11 rx mode", 2, 16'h00E0);
    rd("R11 recv", 4); rd("R11 recv", 4); rd("R11 sts", 3);
    wr("R5 active", 2, 16'h00E4); rd("R5 ctl", 2);
    wr("R5 idle", 2, 16'h00E4);   rd("R5 ctl", 2);
    wr("R5 back", 2, 16'h00E0);
    wr("R9 again", 4, 16'h00A0);
    wr("R3 leave master", 2, 16'h00C0); rd("R3 busy", 3);
    wr("R3 master", 2, 16'h00E0);
    wr("R9 again", 4, 16'h00A0);
    wr("R2 div", 1, 16'h0015);
    wr("R4 soft reset", 2, 16'h0040);
    for (int a = 0; a < 5; a++) rd("R4 after reset", a);
    wr("R6 no ie", 2, 16'h00A0);
    wr("R6 start", 4, 16'h00A0); rd("R6 sts", 3);
    rd("R6 recv", 4); rd("R6 sts", 3);
    wr("R4 soft reset", 2, 16'h0000); rd("R4 own", 0); rd("R4 ctl", 2);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule